// File: doc/BRIEF.md
# DDR3 Command Decoder with Command/Address Parity

This block sits right after the command/address pins of a DDR3 memory device model or controller-side monitor. On every rising clock edge it samples chip select, clock enable, the three active-low command lines, the bank lines and the address lines. From these it produces a set of registered, mutually exclusive command strobes: activate, read, write, single-bank precharge, all-bank precharge, refresh, mode-register load and no-operation. With each strobe it also gives the fields that apply to that command: the bank, the row or op-code, the column, the auto-precharge flag and the mode-register index.

The address bit that normally carries auto-precharge is read in two ways. For a read or write it is the auto-precharge flag. For a precharge it chooses between one bank and all banks. The block also checks even parity over the address lines and the three command lines against a parity input. When the check fails, the command is dropped and an active-low error flag pulses for one cycle. When clock enable is low, no strobe is issued.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: All outputs are registered and show the inputs sampled at the previous rising edge. A synchronous active-high reset clears every strobe and field to 0 and sets the error flag high.
- R2: With chip select high and clock enable high, only the no-operation strobe is raised. The parity check is skipped and the error flag stays high.
- R3: With chip select low, the active-low command lines {ras_n,cas_n,we_n} decode as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode load, 111 no-operation. Code 110 raises no strobe.
- R4: On activate, the bank output carries the bank lines and the row output carries all 15 address bits.
- R5: On read or write, the column output carries address bits 9..0, the auto-precharge output carries address bit 10, and the bank output carries the bank lines.
- R6: On precharge with address bit 10 low, the single-bank strobe fires with the bank lines on the bank output. With address bit 10 high, the all-bank strobe fires and the bank output is 0.
- R7: On mode load, the mode index output carries bank bits 1..0 and the row output carries the address lines as the op-code. Bank bit 2 has no effect on the result.
- R8: Parity is even. The XOR of address bits 14..0, ras_n, cas_n, we_n and the parity input must be 0. If chip select is low and this XOR is 1, the error flag is low in the next cycle, for that one cycle only.
- R9: A cycle with a parity error raises no strobe, and all its fields are 0.
- R10: With clock enable low, no strobe is raised and all fields are 0. Parity is still checked.
- R11: At most one strobe is high in any cycle. Fields that do not belong to the issued command are 0, and the auto-precharge output is high only with a read or write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| cke | input | 1 | Clock enable; low blocks all strobes |
| ras_n | input | 1 | Active-low row strobe command line |
| cas_n | input | 1 | Active-low column strobe command line |
| we_n | input | 1 | Active-low write-enable command line |
| bank_in | input | BANK_W (3) | Bank / mode-register select lines |
| addr_in | input | ROW_W (15) | Address lines |
| par_in | input | 1 | Even parity bit over address and command lines |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| pre_o | output | 1 | Single-bank precharge strobe |
| pre_all_o | output | 1 | All-bank precharge strobe |
| ref_o | output | 1 | Refresh strobe |
| lmr_o | output | 1 | Mode-register load strobe |
| nop_o | output | 1 | No-operation / deselect strobe |
| bank_o | output | BANK_W (3) | Target bank |
| row_o | output | ROW_W (15) | Row address or mode op-code |
| col_o | output | COL_W (10) | Column address |
| ap_o | output | 1 | Auto-precharge flag |
| mr_idx_o | output | MR_W (2) | Mode-register index |
| par_err_n_o | output | 1 | Active-low parity error pulse |

## Verification
Every result of this block appears exactly one rising edge after the inputs that caused it. This covers the strobe, its fields and the parity error flag, because all of them are sourced from the same register stage. The bench drives each stimulus on a falling edge and checks the full output bundle at the next falling edge, which lies half a period after the single capturing edge. The one-cycle width of the error pulse is checked by following a failing cycle with a clean one and sampling again one edge later.

// File: rtl/ddrcmd_pkg.sv
package ddrcmd_pkg;
  typedef enum logic [3:0] {
    CMD_IDLE,
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_PREA,
    CMD_REF,
    CMD_LMR
  } cmd_e;
endpackage

// File: rtl/ddrcmd_classify.sv
module ddrcmd_classify
  import ddrcmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_n) begin
      cmd_o = CMD_NOP;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = a10 ? CMD_PREA : CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_LMR;
        3'b111:  cmd_o = CMD_NOP;
        default: cmd_o = CMD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddrcmd_parity.sv
module ddrcmd_parity #(
  parameter int W = 18
) (
  input  logic [W-1:0] bits_i,
  input  logic         par_i,
  output logic         odd_o
);
  logic [W:0] chain;
  assign chain[0] = par_i;
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ bits_i[i];
  end
  assign odd_o = chain[W];
endmodule

// File: rtl/ddrcmd_fields.sv
module ddrcmd_fields
  import ddrcmd_pkg::*;
#(
  parameter int ROW_W  = 15,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int MR_W   = 2
) (
  input  cmd_e              cmd_i,
  input  logic [ROW_W-1:0]  addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              ap_o,
  output logic [MR_W-1:0]   mr_o
);
  always_comb begin
    bank_o = '0;
    row_o  = '0;
    col_o  = '0;
    ap_o   = 1'b0;
    mr_o   = '0;
    case (cmd_i)
      CMD_ACT: begin
        bank_o = bank_i;
        row_o  = addr_i;
      end
      CMD_RD, CMD_WR: begin
        bank_o = bank_i;
        col_o  = addr_i[COL_W-1:0];
        ap_o   = addr_i[AP_BIT];
      end
      CMD_PRE: bank_o = bank_i;
      CMD_LMR: begin
        row_o = addr_i;
        mr_o  = bank_i[MR_W-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
  import ddrcmd_pkg::*;
#(
  parameter int ROW_W  = 15,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  parameter int AP_BIT = 10,
  parameter int MR_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              cke,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [ROW_W-1:0]  addr_in,
  input  logic              par_in,
  output logic              act_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              pre_o,
  output logic              pre_all_o,
  output logic              ref_o,
  output logic              lmr_o,
  output logic              nop_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              ap_o,
  output logic [MR_W-1:0]   mr_idx_o,
  output logic              par_err_n_o
);
  localparam int PAR_W = ROW_W + 3;

  logic par_odd;
  logic err_now;
  cmd_e raw_cmd;
  cmd_e eff_cmd;

  logic [BANK_W-1:0] f_bank;
  logic [ROW_W-1:0]  f_row;
  logic [COL_W-1:0]  f_col;
  logic              f_ap;
  logic [MR_W-1:0]   f_mr;

  ddrcmd_parity #(.W(PAR_W)) u_par (
    .bits_i ({addr_in, ras_n, cas_n, we_n}),
    .par_i  (par_in),
    .odd_o  (par_odd)
  );

  ddrcmd_classify u_cls (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .a10   (addr_in[AP_BIT]),
    .cmd_o (raw_cmd)
  );

  assign err_now = !cs_n && par_odd;
  assign eff_cmd = (!cke || err_now) ? CMD_IDLE : raw_cmd;

  ddrcmd_fields #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .MR_W(MR_W)
  ) u_fld (
    .cmd_i  (eff_cmd),
    .addr_i (addr_in),
    .bank_i (bank_in),
    .bank_o (f_bank),
    .row_o  (f_row),
    .col_o  (f_col),
    .ap_o   (f_ap),
    .mr_o   (f_mr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o       <= 1'b0;
      rd_o        <= 1'b0;
      wr_o        <= 1'b0;
      pre_o       <= 1'b0;
      pre_all_o   <= 1'b0;
      ref_o       <= 1'b0;
      lmr_o       <= 1'b0;
      nop_o       <= 1'b0;
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      ap_o        <= 1'b0;
      mr_idx_o    <= '0;
      par_err_n_o <= 1'b1;
    end else begin
      act_o       <= (eff_cmd == CMD_ACT);
      rd_o        <= (eff_cmd == CMD_RD);
      wr_o        <= (eff_cmd == CMD_WR);
      pre_o       <= (eff_cmd == CMD_PRE);
      pre_all_o   <= (eff_cmd == CMD_PREA);
      ref_o       <= (eff_cmd == CMD_REF);
      lmr_o       <= (eff_cmd == CMD_LMR);
      nop_o       <= (eff_cmd == CMD_NOP);
      bank_o      <= f_bank;
      row_o       <= f_row;
      col_o       <= f_col;
      ap_o        <= f_ap;
      mr_idx_o    <= f_mr;
      par_err_n_o <= !err_now;
    end
  end

  logic [7:0] stb_vec;
  assign stb_vec = {act_o, rd_o, wr_o, pre_o, pre_all_o, ref_o, lmr_o, nop_o};

  // R11
  onehot_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb_vec));

  // R9
  err_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    !par_err_n_o |-> (stb_vec == 8'd0));

  // R10
  cke_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cke)) |-> (stb_vec == 8'd0));

  // R2
  desel_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cs_n) && $past(cke)) |-> (nop_o && par_err_n_o));

  // R6
  prea_bank_chk: assert property (@(posedge clk) disable iff (rst)
    pre_all_o |-> (bank_o == '0));

  // R5
  ap_only_rw_chk: assert property (@(posedge clk) disable iff (rst)
    ap_o |-> (rd_o || wr_o));
endmodule

// File: tb/ddr_cmd_decoder_tb.sv
module ddr_cmd_decoder_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, cs_n, cke, ras_n, cas_n, we_n, par_in;
  logic [2:0]  bank_in;
  logic [14:0] addr_in;
  logic act_o, rd_o, wr_o, pre_o, pre_all_o, ref_o, lmr_o, nop_o, ap_o, par_err_n_o;
  logic [2:0]  bank_o;
  logic [14:0] row_o;
  logic [9:0]  col_o;
  logic [1:0]  mr_idx_o;

  ddr_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cke(cke), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank_in(bank_in), .addr_in(addr_in), .par_in(par_in),
    .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o), .pre_all_o(pre_all_o),
    .ref_o(ref_o), .lmr_o(lmr_o), .nop_o(nop_o), .bank_o(bank_o), .row_o(row_o),
    .col_o(col_o), .ap_o(ap_o), .mr_idx_o(mr_idx_o), .par_err_n_o(par_err_n_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // strobe order: act rd wr pre pre_all ref lmr nop
  typedef struct packed {
    logic        flip;
    logic        cs;
    logic        ck;
    logic [2:0]  cmd;
    logic [2:0]  ba;
    logic [14:0] a;
    logic [7:0]  stb;
    logic        errn;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 3'b011, 3'd5, 15'h1234, 8'b1000_0000, 1'b1},
    '{1'b0, 1'b0, 1'b1, 3'b101, 3'd3, 15'h02AB, 8'b0100_0000, 1'b1},
    '{1'b0, 1'b0, 1'b1, 3'b100, 3'd7, 15'h7C55, 8'b0010_0000, 1'b1},
    '{1'b0, 1'b0, 1'b1, 3'b010, 3'd2, 15'h0000, 8'b0001_0000, 1'b1},
    '{1'b0, 1'b0, 1'b1, 3'b010, 3'd6, 15'h0400, 8'b0000_1000, 1'b1},
    '{1'b0, 1'b0, 1'b1, 3'b001, 3'd1, 15'h0011, 8'b0000_0100, 1'b1},
    '{1'b0, 1'b0, 1'b1, 3'b000, 3'd6, 15'h0A5A, 8'b0000_0010, 1'b1},
    '{1'b0, 1'b0, 1'b1, 3'b111, 3'd4, 15'h7FFF, 8'b0000_0001, 1'b1},
    '{1'b1, 1'b1, 1'b1, 3'b011, 3'd1, 15'h0F0F, 8'b0000_0001, 1'b1},
    '{1'b0, 1'b0, 1'b1, 3'b110, 3'd2, 15'h0123, 8'b0000_0000, 1'b1},
    '{1'b0, 1'b0, 1'b0, 3'b011, 3'd5, 15'h1234, 8'b0000_0000, 1'b1},
    '{1'b1, 1'b0, 1'b1, 3'b011, 3'd5, 15'h1234, 8'b0000_0000, 1'b0},
    '{1'b1, 1'b0, 1'b0, 3'b101, 3'd0, 15'h0001, 8'b0000_0000, 1'b0},
    '{1'b1, 1'b0, 1'b1, 3'b101, 3'd3, 15'h04AB, 8'b0000_0000, 1'b0}
  };

  function automatic string tag_of(int i);
    case (i)
      0:  return "R4";
      1:  return "R5";
      2:  return "R5";
      3:  return "R6";
      4:  return "R6";
      5:  return "R3";
      6:  return "R7";
      7:  return "R3";
      8:  return "R2";
      9:  return "R11";
      10: return "R10";
      11: return "R9";
      12: return "R8";
      default: return "R8";
    endcase
  endfunction

  // expected bundle: stb(8) bank(3) row(15) col(10) ap(1) mr(2) errn(1)
  function automatic logic [39:0] expect_of(vec_t v);
    logic [2:0]  b = '0;
    logic [14:0] r = '0;
    logic [9:0]  c = '0;
    logic        ap = 1'b0;
    logic [1:0]  m = '0;
    if (v.stb[7]) begin b = v.ba; r = v.a; end
    if (v.stb[6] || v.stb[5]) begin b = v.ba; c = v.a[9:0]; ap = v.a[10]; end
    if (v.stb[4]) b = v.ba;
    if (v.stb[1]) begin r = v.a; m = v.ba[1:0]; end
    return {v.stb, b, r, c, ap, m, v.errn};
  endfunction

  function automatic logic [39:0] got_bundle();
    return {act_o, rd_o, wr_o, pre_o, pre_all_o, ref_o, lmr_o, nop_o,
            bank_o, row_o, col_o, ap_o, mr_idx_o, par_err_n_o};
  endfunction

  task automatic drive(vec_t v);
    cs_n    = v.cs;
    cke     = v.ck;
    {ras_n, cas_n, we_n} = v.cmd;
    bank_in = v.ba;
    addr_in = v.a;
    par_in  = (^{v.a, v.cmd}) ^ v.flip;
  endtask

  task automatic check(string tag, logic [39:0] exp);
    logic [39:0] got = got_bundle();
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #20000;
    bad++;
    total++;
    $display("FAIL watchdog: got=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    drive('{1'b0, 1'b0, 1'b1, 3'b011, 3'd7, 15'h7FFF, 8'h00, 1'b1});
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {8'h00, 3'd0, 15'd0, 10'd0, 1'b0, 2'd0, 1'b1});
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check(tag_of(i), expect_of(VEC[i]));
    end

    // R8: error pulse lasts one cycle; next clean command is issued
    drive('{1'b1, 1'b0, 1'b1, 3'b001, 3'd0, 15'h0003, 8'h00, 1'b0});
    @(negedge clk);
    check("R8", {8'h00, 3'd0, 15'd0, 10'd0, 1'b0, 2'd0, 1'b0});
    drive('{1'b0, 1'b0, 1'b1, 3'b001, 3'd0, 15'h0003, 8'h00, 1'b1});
    @(negedge clk);
    check("R8", {8'b0000_0100, 3'd0, 15'd0, 10'd0, 1'b0, 2'd0, 1'b1});

    // R7: bank bit 2 has no effect on mode load
    drive('{1'b0, 1'b0, 1'b1, 3'b000, 3'd3, 15'h1357, 8'h00, 1'b1});
    @(negedge clk);
    check("R7", {8'b0000_0010, 3'd0, 15'h1357, 10'd0, 1'b0, 2'd3, 1'b1});
    drive('{1'b0, 1'b0, 1'b1, 3'b000, 3'd7, 15'h1357, 8'h00, 1'b1});
    @(negedge clk);
    check("R7", {8'b0000_0010, 3'd0, 15'h1357, 10'd0, 1'b0, 2'd3, 1'b1});

    // R1: reset mid-stream clears an issued write
    drive('{1'b0, 1'b0, 1'b1, 3'b100, 3'd4, 15'h07FF, 8'h00, 1'b1});
    @(negedge clk);
    check("R5", {8'b0010_0000, 3'd4, 15'd0, 10'h3FF, 1'b1, 2'd0, 1'b1});
    rst = 1'b1;
    @(negedge clk);
    check("R1", {8'h00, 3'd0, 15'd0, 10'd0, 1'b0, 2'd0, 1'b1});
    rst = 1'b0;
    @(negedge clk);

    finish_run();
  end
endmodule